// File: doc/BRIEF.md
# Two-Channel Cycle-Steal DMA Controller

This block moves data between locations of a 20-bit byte address space without processor help. It has two independent channels. Each accepted request costs exactly one transfer: the block takes the bus for one read cycle at the source address, then one write cycle at the destination address with the data just read, and then gives the bus back. Each transfer moves an 8-bit or a 16-bit unit. For each channel, software picks the unit size, whether the source or the destination address steps forward (at most one of them), and whether the channel stops or restarts when its count runs out.

Software sets up a channel through a small register port. A request can come from a per-channel request line or from a trigger bit in the channel's control register. A 16-bit transfer counter counts the units of a block. When the counter runs below zero the channel raises a one-cycle interrupt. It then either switches itself off (single mode) or reloads its counter and keeps running (repeat mode). The transfers do not depend on any processor interrupt masking, because the block has no input for it.

Top module: `dual_dma_ctrl`

Register map: `reg_addr[3]` selects the channel and `reg_addr[2:0]` selects the register.
- 0: source pointer (20 bits)
- 1: destination pointer (20 bits)
- 2: count reload (16 bits)
- 3: live counter (read only)
- 4: control

Control register bits:
- bit 0: enable
- bit 1: 16-bit unit
- bit 2: source steps forward
- bit 3: destination steps forward
- bit 4: repeat mode
- bit 5: software trigger (write only, reads as 0)

## Requirements
- R1: After reset every register reads 0, `m_valid` is 0 and `irq_o` is 0.
- R2: A transfer is a read cycle (`m_write`=0) at the source address, then a write cycle (`m_write`=1) at the destination address that carries the read data. Each cycle holds `m_valid`, `m_addr` and `m_write` steady until `m_ready` is seen. `m_wide` is 1 for 16-bit units.
- R3: When both channels have a request waiting while the bus port is idle, channel 0 is served first.
- R4: The forward address steps by 1 after an 8-bit unit and by 2 after a 16-bit unit, and wraps modulo 2^20. The fixed-side address never changes.
- R5: On the first transfer after enable goes from 0 to 1, the forward working address is loaded from the forward-side pointer register and the counter is loaded from the reload register.
- R6: In single mode the counter is decremented after each transfer. The transfer that finds the counter at 0 clears enable (control bit 0 reads 0) and pulses that channel's `irq_o` bit high for one cycle. A reload value N therefore gives N+1 transfers.
- R7: In repeat mode the transfer that finds the counter at 0 reloads the counter from the reload register and pulses `irq_o`, and enable stays 1 until software writes 0 to it.
- R8: While enabled, a write to the pointer register of the fixed side is ignored, and a write to the forward-side pointer register is accepted. While enabled, a control write changes only the enable bit and the trigger, and the other control bits keep their values.
- R9: While enabled and after the first transfer, reading the forward-side pointer register returns the working address. Otherwise it returns the register's stored value.
- R10: Requests and triggers are ignored while the channel is disabled. Any number of requests that arrive while a request is waiting merge into one, and a new request that arrives during the grant cycle or during the transfer is held and served once afterwards.
- R11: Writing control bit 5 as 1, with enable 1 after the write, starts one transfer just as a request-line pulse does.
- R12: A control write that sets both forward bits keeps the source forward bit and clears the destination forward bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register select: channel in bit 3, register in bits 2:0 |
| reg_wdata | input | 20 | Register write data |
| reg_rdata | output | 20 | Read data for the register at `reg_addr` (combinational) |
| req_i | input | 2 | Request line per channel, one request per cycle high |
| m_valid | output | 1 | Bus cycle valid |
| m_write | output | 1 | 1 for a write cycle, 0 for a read cycle |
| m_wide | output | 1 | 1 for a 16-bit unit, 0 for an 8-bit unit |
| m_addr | output | 20 | Bus byte address |
| m_wdata | output | 16 | Write data |
| m_rdata | input | 16 | Read data, taken when `m_valid` and `m_ready` are both 1 in a read cycle |
| m_ready | input | 1 | Bus cycle completes at this edge |
| irq_o | output | 2 | One-cycle underflow interrupt per channel |

## Verification
On every cycle the assertions check the bus handshake. A held cycle keeps its address and direction, every write follows a completed read, and every completed read is followed by a write. They also check that an interrupt lasts a single cycle and comes from one channel at a time, that a single-mode channel is off by the time its interrupt appears, and that the two forward bits are never set together. The bench scenarios are needed for the rest. They show the sequences of addresses across wrap and reload, when the working pointer is loaded, that a protected write leaves the register unchanged, the readback of the live pointer, which channel wins, and that requests merge into exactly one extra transfer.

// File: rtl/dual_dma_pkg.sv
package dual_dma_pkg;

    // Register selectors within one channel window
    localparam logic [2:0] SEL_SRC  = 3'd0;
    localparam logic [2:0] SEL_DST  = 3'd1;
    localparam logic [2:0] SEL_RLD  = 3'd2;
    localparam logic [2:0] SEL_CNT  = 3'd3;
    localparam logic [2:0] SEL_CTRL = 3'd4;

    // Control bit positions
    localparam int CB_EN   = 0;
    localparam int CB_WIDE = 1;
    localparam int CB_SINC = 2;
    localparam int CB_DINC = 3;
    localparam int CB_RPT  = 4;
    localparam int CB_TRIG = 5;

    typedef struct packed {
        logic repeat_mode;
        logic dst_inc;
        logic src_inc;
        logic wide;
        logic enable;
    } chan_ctrl_t;

    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_READ  = 2'd1,
        BUS_WRITE = 2'd2
    } bus_state_e;

endpackage

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
    parameter int NUM_CH = 2,
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [NUM_CH-1:0] req,
    output logic              any_o,
    output logic [IDX_W-1:0]  idx_o
);

    // Lowest index wins
    always_comb begin
        idx_o = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx_o = IDX_W'(i);
            end
        end
        any_o = |req;
    end

endmodule

// File: rtl/dma_bus_engine.sv
module dma_bus_engine
    import dual_dma_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int NUM_CH = 2,
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [IDX_W-1:0]  start_ch_i,
    input  logic [ADDR_W-1:0] src_i,
    input  logic [ADDR_W-1:0] dst_i,
    input  logic              wide_i,
    output logic              idle_o,
    output logic [NUM_CH-1:0] done_o,
    output logic              m_valid,
    output logic              m_write,
    output logic              m_wide,
    output logic [ADDR_W-1:0] m_addr,
    output logic [DATA_W-1:0] m_wdata,
    input  logic [DATA_W-1:0] m_rdata,
    input  logic              m_ready
);

    typedef struct packed {
        bus_state_e        st;
        logic [IDX_W-1:0]  ch;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic              wide;
        logic [DATA_W-1:0] data;
    } eng_t;

    eng_t eng_d, eng_q;

    always_comb begin
        eng_d = eng_q;
        case (eng_q.st)
            BUS_IDLE: begin
                if (start_i) begin
                    eng_d.st   = BUS_READ;
                    eng_d.ch   = start_ch_i;
                    eng_d.src  = src_i;
                    eng_d.dst  = dst_i;
                    eng_d.wide = wide_i;
                end
            end
            BUS_READ: begin
                if (m_ready) begin
                    eng_d.data = m_rdata;
                    eng_d.st   = BUS_WRITE;
                end
            end
            BUS_WRITE: begin
                if (m_ready) begin
                    eng_d.st = BUS_IDLE;
                end
            end
            default: eng_d.st = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '{st: BUS_IDLE, default: '0};
        end else begin
            eng_q <= eng_d;
        end
    end

    always_comb begin
        done_o = '0;
        if (eng_q.st == BUS_WRITE && m_ready) begin
            done_o[eng_q.ch] = 1'b1;
        end
    end

    assign idle_o  = (eng_q.st == BUS_IDLE);
    assign m_valid = (eng_q.st != BUS_IDLE);
    assign m_write = (eng_q.st == BUS_WRITE);
    assign m_wide  = eng_q.wide;
    assign m_addr  = (eng_q.st == BUS_WRITE) ? eng_q.dst : eng_q.src;
    assign m_wdata = eng_q.data;

endmodule

// File: rtl/dma_channel.sv
module dma_channel
    import dual_dma_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [2:0]        sel_i,
    input  logic [ADDR_W-1:0] wdata_i,
    output logic [ADDR_W-1:0] rdata_o,
    input  logic              req_i,
    input  logic              grant_i,
    input  logic              done_i,
    output logic              pend_o,
    output logic [ADDR_W-1:0] src_addr_o,
    output logic [ADDR_W-1:0] dst_addr_o,
    output logic              wide_o,
    output logic              irq_o,
    output logic              en_o,
    output logic              rpt_o,
    output logic              src_inc_o,
    output logic              dst_inc_o
);

    localparam int CTRL_W = $bits(chan_ctrl_t);

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [ADDR_W-1:0] fwd;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  rld;
        chan_ctrl_t        ctrl;
        logic              first;
        logic              pend;
        logic              irq;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     trig;
    logic [ADDR_W-1:0] step;

    assign step = st_q.ctrl.wide ? ADDR_W'(2) : ADDR_W'(1);

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        trig     = 1'b0;

        // Register writes
        if (wr_en_i) begin
            case (sel_i)
                SEL_SRC: if (st_q.ctrl.src_inc || !st_q.ctrl.enable) st_d.src = wdata_i;
                SEL_DST: if (st_q.ctrl.dst_inc || !st_q.ctrl.enable) st_d.dst = wdata_i;
                SEL_RLD: st_d.rld = wdata_i[CNT_W-1:0];
                SEL_CTRL: begin
                    st_d.ctrl.enable = wdata_i[CB_EN];
                    if (!st_q.ctrl.enable) begin
                        st_d.ctrl.wide        = wdata_i[CB_WIDE];
                        st_d.ctrl.src_inc     = wdata_i[CB_SINC];
                        st_d.ctrl.dst_inc     = wdata_i[CB_DINC] & ~wdata_i[CB_SINC];
                        st_d.ctrl.repeat_mode = wdata_i[CB_RPT];
                        if (wdata_i[CB_EN]) begin
                            st_d.first = 1'b1;
                        end
                    end
                    trig = wdata_i[CB_TRIG];
                end
                default: ;
            endcase
        end

        // Start of a transfer: consume request, load working state once
        if (grant_i) begin
            st_d.pend = 1'b0;
            if (st_q.first) begin
                st_d.fwd   = st_q.ctrl.src_inc ? st_q.src : st_q.dst;
                st_d.cnt   = st_q.rld;
                st_d.first = 1'b0;
            end
        end

        // End of a transfer: advance pointer, count, underflow handling
        if (done_i) begin
            st_d.fwd = st_q.fwd + step;
            if (st_q.cnt == '0) begin
                st_d.irq = 1'b1;
                if (st_q.ctrl.repeat_mode) begin
                    st_d.cnt = st_q.rld;
                end else begin
                    st_d.ctrl.enable = 1'b0;
                end
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end

        // Request capture, merged into one pending flag
        if (st_d.ctrl.enable && (req_i || trig)) begin
            st_d.pend = 1'b1;
        end
        if (!st_d.ctrl.enable) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Addresses for the transfer about to start
    always_comb begin
        src_addr_o = st_q.src;
        dst_addr_o = st_q.dst;
        if (st_q.ctrl.src_inc) begin
            src_addr_o = st_q.first ? st_q.src : st_q.fwd;
        end
        if (st_q.ctrl.dst_inc) begin
            dst_addr_o = st_q.first ? st_q.dst : st_q.fwd;
        end
    end

    // Register readback
    always_comb begin
        logic live;
        live    = st_q.ctrl.enable && !st_q.first;
        rdata_o = '0;
        case (sel_i)
            SEL_SRC:  rdata_o = (live && st_q.ctrl.src_inc) ? st_q.fwd : st_q.src;
            SEL_DST:  rdata_o = (live && st_q.ctrl.dst_inc) ? st_q.fwd : st_q.dst;
            SEL_RLD:  rdata_o = {{(ADDR_W-CNT_W){1'b0}}, st_q.rld};
            SEL_CNT:  rdata_o = {{(ADDR_W-CNT_W){1'b0}}, st_q.cnt};
            SEL_CTRL: rdata_o = {{(ADDR_W-CTRL_W){1'b0}}, st_q.ctrl};
            default:  rdata_o = '0;
        endcase
    end

    assign pend_o    = st_q.pend && st_q.ctrl.enable;
    assign wide_o    = st_q.ctrl.wide;
    assign irq_o     = st_q.irq;
    assign en_o      = st_q.ctrl.enable;
    assign rpt_o     = st_q.ctrl.repeat_mode;
    assign src_inc_o = st_q.ctrl.src_inc;
    assign dst_inc_o = st_q.ctrl.dst_inc;

endmodule

// File: rtl/dual_dma_ctrl.sv
module dual_dma_ctrl
    import dual_dma_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16,
    parameter int NUM_CH = 2,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int RA_W  = CH_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic [NUM_CH-1:0] req_i,
    output logic              m_valid,
    output logic              m_write,
    output logic              m_wide,
    output logic [ADDR_W-1:0] m_addr,
    output logic [DATA_W-1:0] m_wdata,
    input  logic [DATA_W-1:0] m_rdata,
    input  logic              m_ready,
    output logic [NUM_CH-1:0] irq_o
);

    logic [CH_W-1:0]   reg_ch;
    logic [2:0]        reg_sel;
    logic [ADDR_W-1:0] ch_rdata [NUM_CH];
    logic [ADDR_W-1:0] ch_src   [NUM_CH];
    logic [ADDR_W-1:0] ch_dst   [NUM_CH];
    logic [NUM_CH-1:0] ch_wide;
    logic [NUM_CH-1:0] ch_pend;
    logic [NUM_CH-1:0] ch_grant;
    logic [NUM_CH-1:0] ch_done;
    logic [NUM_CH-1:0] dbg_en;
    logic [NUM_CH-1:0] dbg_rpt;
    logic [NUM_CH-1:0] dbg_sinc;
    logic [NUM_CH-1:0] dbg_dinc;
    logic              arb_any;
    logic [CH_W-1:0]   arb_idx;
    logic              eng_idle;
    logic              start;

    assign reg_ch  = reg_addr[RA_W-1:3];
    assign reg_sel = reg_addr[2:0];

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            dma_channel #(
                .ADDR_W (ADDR_W),
                .CNT_W  (CNT_W)
            ) u_chan (
                .clk        (clk),
                .rst_n      (rst_n),
                .wr_en_i    (reg_we && (reg_ch == CH_W'(g))),
                .sel_i      (reg_sel),
                .wdata_i    (reg_wdata),
                .rdata_o    (ch_rdata[g]),
                .req_i      (req_i[g]),
                .grant_i    (ch_grant[g]),
                .done_i     (ch_done[g]),
                .pend_o     (ch_pend[g]),
                .src_addr_o (ch_src[g]),
                .dst_addr_o (ch_dst[g]),
                .wide_o     (ch_wide[g]),
                .irq_o      (irq_o[g]),
                .en_o       (dbg_en[g]),
                .rpt_o      (dbg_rpt[g]),
                .src_inc_o  (dbg_sinc[g]),
                .dst_inc_o  (dbg_dinc[g])
            );
            assign ch_grant[g] = start && (arb_idx == CH_W'(g));
        end
    endgenerate

    assign reg_rdata = ch_rdata[reg_ch];

    dma_prio_arb #(
        .NUM_CH (NUM_CH)
    ) u_arb (
        .req   (ch_pend),
        .any_o (arb_any),
        .idx_o (arb_idx)
    );

    assign start = arb_any && eng_idle;

    dma_bus_engine #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .NUM_CH (NUM_CH)
    ) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .start_ch_i (arb_idx),
        .src_i      (ch_src[arb_idx]),
        .dst_i      (ch_dst[arb_idx]),
        .wide_i     (ch_wide[arb_idx]),
        .idle_o     (eng_idle),
        .done_o     (ch_done),
        .m_valid    (m_valid),
        .m_write    (m_write),
        .m_wide     (m_wide),
        .m_addr     (m_addr),
        .m_wdata    (m_wdata),
        .m_rdata    (m_rdata),
        .m_ready    (m_ready)
    );

endmodule

// File: rtl/dual_dma_checker.sv
module dual_dma_checker #(
    parameter int ADDR_W = 20,
    parameter int NUM_CH = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              m_valid,
    input logic              m_write,
    input logic              m_ready,
    input logic [ADDR_W-1:0] m_addr,
    input logic [NUM_CH-1:0] irq_o,
    input logic [NUM_CH-1:0] ch_en,
    input logic [NUM_CH-1:0] ch_rpt,
    input logic [NUM_CH-1:0] ch_sinc,
    input logic [NUM_CH-1:0] ch_dinc
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_idle_R1: assert (!m_valid && irq_o == '0)
                else $error("bus or interrupt active in reset");
        end
    end

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_write)));

    assert_read_then_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_write && m_ready) |=> (m_valid && m_write));

    assert_write_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_write && !$past(m_valid && m_write)) |-> $past(m_valid && !m_write && m_ready));

    assert_irq_single_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_o));

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
            assert_irq_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
                irq_o[g] |=> !irq_o[g]);

            assert_single_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (irq_o[g] && !ch_rpt[g]) |-> !ch_en[g]);

            assert_legal_dirs_R12: assert property (@(posedge clk) disable iff (!rst_n)
                !(ch_sinc[g] && ch_dinc[g]));
        end
    endgenerate

endmodule

bind dual_dma_ctrl dual_dma_checker #(
    .ADDR_W (ADDR_W),
    .NUM_CH (NUM_CH)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .m_valid (m_valid),
    .m_write (m_write),
    .m_ready (m_ready),
    .m_addr  (m_addr),
    .irq_o   (irq_o),
    .ch_en   (dbg_en),
    .ch_rpt  (dbg_rpt),
    .ch_sinc (dbg_sinc),
    .ch_dinc (dbg_dinc)
);

// File: tb/dual_dma_ctrl_bench.sv
`timescale 1ns/1ps
module dual_dma_ctrl_bench;

    typedef struct packed {
        logic        wr;
        logic        wide;
        logic [19:0] addr;
        logic [15:0] data;
    } beat_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [19:0] reg_wdata = '0;
    logic [19:0] reg_rdata;
    logic [1:0]  req_i = '0;
    logic        m_valid, m_write, m_wide;
    logic [19:0] m_addr;
    logic [15:0] m_wdata, m_rdata;
    logic        m_ready;
    logic [1:0]  irq_o;

    int checks = 0;
    int fails  = 0;
    int beats  = 0;
    int irq_cnt [2] = '{0, 0};
    logic stall = 1'b0;
    logic [2:0] rcnt = '0;
    beat_t exp_q [$];

    always #4 clk = ~clk;

    function automatic logic [15:0] mem_rd(input logic [19:0] a);
        return a[15:0] ^ 16'hA5C3 ^ {a[19:16], 12'h000};
    endfunction

    always @(posedge clk) rcnt <= rcnt + 3'd1;
    assign m_ready = stall ? (rcnt == 3'd0) : 1'b1;
    assign m_rdata = mem_rd(m_addr);

    dual_dma_ctrl u_dual_dma_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_i(req_i),
        .m_valid(m_valid), .m_write(m_write), .m_wide(m_wide), .m_addr(m_addr),
        .m_wdata(m_wdata), .m_rdata(m_rdata), .m_ready(m_ready), .irq_o(irq_o)
    );

    task automatic check(input bit ok, input string tag, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Monitor: compares each completed bus cycle with the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            irq_cnt[0] += int'(irq_o[0]);
            irq_cnt[1] += int'(irq_o[1]);
            if (m_valid && m_ready) begin
                beats++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10 unexpected bus cycle", {m_write, m_wide, m_addr, 18'h0}, '0);
                end else begin
                    beat_t e;
                    e = exp_q.pop_front();
                    if (m_write) begin
                        check({m_write, m_wide, m_addr, m_wdata} == e, "R2 R4 write cycle",
                              {m_write, m_wide, m_addr, m_wdata}, e);
                    end else begin
                        check({m_write, m_wide, m_addr} == {e.wr, e.wide, e.addr}, "R2 R4 read cycle",
                              {m_write, m_wide, m_addr, 16'h0}, {e.wr, e.wide, e.addr, 16'h0});
                    end
                end
            end
        end
    end

    // Driver: expected transfer onto the scoreboard
    task automatic push_xfer(input logic [19:0] s, input logic [19:0] d, input logic w);
        exp_q.push_back('{wr: 1'b0, wide: w, addr: s, data: 16'h0});
        exp_q.push_back('{wr: 1'b1, wide: w, addr: d, data: mem_rd(s)});
    endtask

    task automatic wr(input logic [3:0] a, input logic [19:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_check(input logic [3:0] a, input logic [19:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(reg_rdata == exp, tag, {20'h0, reg_rdata}, {20'h0, exp});
    endtask

    task automatic pulse(input logic [1:0] r, input int n);
        @(negedge clk);
        req_i = r;
        repeat (n) @(negedge clk);
        req_i = '0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drained(input string tag);
        check(exp_q.size() == 0, tag, 40'(exp_q.size()), '0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        int b0;
        settle(3);
        check(!m_valid && irq_o == 2'b00, "R1 bus and irq idle in reset", {38'h0, m_valid, irq_o[0]}, '0);
        rst_n = 1'b1;
        rd_check(4'h0, 20'h0, "R1 source reset");
        rd_check(4'h2, 20'h0, "R1 reload reset");
        rd_check(4'hC, 20'h0, "R1 control reset");

        // Single mode, source forward, byte units, reload 2
        wr(4'h0, 20'h00100);
        wr(4'h1, 20'h40000);
        wr(4'h2, 20'd2);
        wr(4'h4, 20'h05);
        push_xfer(20'h00100, 20'h40000, 1'b0);
        pulse(2'b01, 1);
        settle(10);
        rd_check(4'h0, 20'h00101, "R9 live forward pointer");
        rd_check(4'h3, 20'd1, "R5 counter loaded then decremented");
        wr(4'h1, 20'h55555);
        rd_check(4'h1, 20'h40000, "R8 fixed pointer protected");
        wr(4'h0, 20'h00200);
        push_xfer(20'h00101, 20'h40000, 1'b0);
        pulse(2'b01, 1);
        settle(10);
        push_xfer(20'h00102, 20'h40000, 1'b0);
        pulse(2'b01, 1);
        settle(10);
        drained("R6 three transfers for reload 2");
        rd_check(4'h4, 20'h04, "R6 single mode clears enable");
        check(irq_cnt[0] == 1, "R6 one interrupt", 40'(irq_cnt[0]), 40'd1);
        rd_check(4'h0, 20'h00200, "R8 forward pointer write accepted");

        // Repeat mode, destination forward, 16-bit, with wrap and stalls
        stall = 1'b1;
        wr(4'h8, 20'h12340);
        wr(4'h9, 20'hFFFFE);
        wr(4'hA, 20'd1);
        wr(4'hC, 20'h1B);
        push_xfer(20'h12340, 20'hFFFFE, 1'b1);
        wr(4'hC, 20'h3B);
        settle(30);
        push_xfer(20'h12340, 20'h00000, 1'b1);
        pulse(2'b10, 1);
        settle(30);
        push_xfer(20'h12340, 20'h00002, 1'b1);
        wr(4'hC, 20'h20 | 20'h01);
        settle(30);
        push_xfer(20'h12340, 20'h00004, 1'b1);
        pulse(2'b10, 1);
        settle(30);
        drained("R11 R4 repeat transfers with wrap");
        check(irq_cnt[1] == 2, "R7 interrupt per block", 40'(irq_cnt[1]), 40'd2);
        rd_check(4'hC, 20'h1B, "R7 repeat keeps enable");
        rd_check(4'hB, 20'd1, "R7 counter reloaded");
        wr(4'hC, 20'h00);
        rd_check(4'hC, 20'h1A, "R8 control bits kept while enabled");
        wr(4'hC, 20'h3B);
        push_xfer(20'h12340, 20'hFFFFE, 1'b1);
        settle(30);
        drained("R5 working pointer reloaded on re-enable");
        rd_check(4'hB, 20'd0, "R5 counter reloaded on re-enable");
        rd_check(4'h9, 20'h00000, "R9 R4 live destination after wrap");
        wr(4'hC, 20'h00);

        // Priority: both channels request in the same cycle
        wr(4'h0, 20'h00010);
        wr(4'h1, 20'h00020);
        wr(4'h2, 20'd5);
        wr(4'h4, 20'h09);
        wr(4'h8, 20'h00030);
        wr(4'h9, 20'h00040);
        wr(4'hA, 20'd0);
        wr(4'hC, 20'h13);
        push_xfer(20'h00010, 20'h00020, 1'b0);
        push_xfer(20'h00030, 20'h00040, 1'b1);
        pulse(2'b11, 1);
        settle(60);
        drained("R3 channel 0 served first");
        check(irq_cnt[1] == 3, "R7 reload 0 interrupts each transfer", 40'(irq_cnt[1]), 40'd3);

        // Merging: request held three cycles gives exactly two transfers
        b0 = beats;
        push_xfer(20'h00010, 20'h00021, 1'b0);
        push_xfer(20'h00010, 20'h00022, 1'b0);
        pulse(2'b01, 3);
        settle(80);
        drained("R10 merged requests served");
        check(beats == b0 + 4, "R10 exactly two transfers", 40'(beats - b0), 40'd4);

        // Illegal directions and ignored requests while disabled
        stall = 1'b0;
        wr(4'h4, 20'h00);
        wr(4'h4, 20'h0C);
        rd_check(4'h4, 20'h04, "R12 destination forward dropped");
        b0 = beats;
        pulse(2'b01, 2);
        wr(4'h4, 20'h24);
        settle(20);
        check(beats == b0, "R10 disabled channel ignores requests", 40'(beats - b0), 40'd0);
        rd_check(4'h4, 20'h04, "R11 trigger not stored");

        summary();
        $finish;
    end

endmodule